// File: doc/BRIEF.md
# Permuted Three-Bit Cycle Counter

This block is a synchronous counter whose three state bits step through a fixed, non-binary cycle that covers all eight codes: 0, 7, 4, 5, 6, 3, 2, 1, and then 0 again. Each state bit sits in its own D-type register and drives its output pin directly. The next value of each bit comes from a separate sum-of-products equation over the three current bits. Nothing in the design looks up the next code in a case table.

A count-enable input lets the surrounding logic pause the cycle. A synchronous active-high reset returns the counter to code 0. Each time the cycle closes, meaning an enabled step from code 1 to code 0, a registered wrap flag goes high for exactly one clock cycle. Every one of the eight codes lies on the cycle, so no power-up value can trap the counter.

Top module: `perm_counter`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, the next state is `q` = 3'b000 and `wrap` = 0, whatever the value of `en`.
- R2: With `rst` low and `en` high, each rising edge moves `q` to the code that follows it in the cycle 0→7→4→5→6→3→2→1→0. The code is read as the binary number {q[2], q[1], q[0]}, with q[2] as the most significant bit.
- R3: With `rst` low and `en` low, `q` keeps its value across the rising edge.
- R4: `wrap` is 1 during the cycle that follows a rising edge at which `rst` was low, `en` was high and `q` was 3'b001. In every other cycle `wrap` is 0.
- R5: Starting from any code on the cycle, eight enabled steps bring `q` back to that same code, and the codes passed on the way are all eight values, each seen once.
- R6: `q` and `wrap` change only at rising edges of `clk`. A pulse on `en` that starts and ends between two rising edges leaves both outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk  | input  | 1 | Clock; the state changes on its rising edge |
| rst  | input  | 1 | Synchronous reset, active high; takes priority over `en` |
| en   | input  | 1 | Count enable; when low, the state holds |
| q    | output | 3 | State register contents; q[2] is the MSB |
| wrap | output | 1 | One-cycle flag after the step from code 1 to code 0 |

## Verification
The properties assume that `rst` and `en` are stable at each rising edge of `clk`. They also assume that `rst` is high at the first edge, so the first state that counts is a known 000. The stimulus meets both assumptions: it changes `en` and `rst` only at falling edges, and it holds reset high from time zero. The one exception is the R6 test, which deliberately pulses `en` between two edges. That pulse still begins after a falling edge and ends before the next rising edge, so no rising edge ever samples it. These assumptions make the step, hold and wrap properties well defined from the first cycle after reset.

// File: rtl/perm_counter_pkg.sv
package perm_counter_pkg;
  localparam int unsigned STATE_W = 3;
  localparam int unsigned NUM_CODES = 1 << STATE_W;
  typedef logic [STATE_W-1:0] state_t;
  localparam state_t CODE_ZERO = '0;
  localparam state_t CODE_LAST = state_t'(1);
endpackage

// File: rtl/perm_next_logic.sv
module perm_next_logic
  import perm_counter_pkg::*;
(
  input  state_t cur,
  output state_t nxt
);
  logic b2, b1, b0;
  assign b2 = cur[2];
  assign b1 = cur[1];
  assign b0 = cur[0];

  // Bit 2: true for codes 0, 4, 5, 7
  assign nxt[2] = (~b1 & ~b0) | (b2 & b0);
  // Bit 1: true for codes 0, 3, 5, 6 (odd parity inverted)
  assign nxt[1] = (~b2 & ~b1 & ~b0) | (~b2 & b1 & b0)
                | ( b2 & ~b1 & b0)  | ( b2 & b1 & ~b0);
  // Bit 0: true for even codes
  assign nxt[0] = ~b0;
endmodule

// File: rtl/perm_state_reg.sv
module perm_state_reg #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk) begin
      if (rst)     bit_q <= 1'b0;
      else if (en) bit_q <= d[i];
    end
    assign q[i] = bit_q;
  end
endmodule

// File: rtl/perm_wrap_detect.sv
module perm_wrap_detect #(
  parameter int unsigned W = 3,
  parameter logic [W-1:0] FROM_CODE = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] cur,
  output logic         wrap
);
  logic wrap_q;
  always_ff @(posedge clk) begin
    if (rst) wrap_q <= 1'b0;
    else     wrap_q <= en && (cur == FROM_CODE);
  end
  assign wrap = wrap_q;
endmodule

// File: rtl/perm_counter.sv
module perm_counter
  import perm_counter_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  output logic [STATE_W-1:0] q,
  output logic               wrap
);
  state_t state;
  state_t next_state;

  perm_next_logic u_next (
    .cur (state),
    .nxt (next_state)
  );

  perm_state_reg #(.W(STATE_W)) u_reg (
    .clk (clk),
    .rst (rst),
    .en  (en),
    .d   (next_state),
    .q   (state)
  );

  perm_wrap_detect #(.W(STATE_W), .FROM_CODE(CODE_LAST)) u_wrap (
    .clk  (clk),
    .rst  (rst),
    .en   (en),
    .cur  (state),
    .wrap (wrap)
  );

  assign q = state;
endmodule

// File: rtl/perm_counter_chk.sv
module perm_counter_chk (
  input logic       clk,
  input logic       rst,
  input logic       en,
  input logic [2:0] q,
  input logic       wrap
);
  function automatic logic [2:0] succ(input logic [2:0] c);
    case (c)
      3'd0: succ = 3'd7;
      3'd7: succ = 3'd4;
      3'd4: succ = 3'd5;
      3'd5: succ = 3'd6;
      3'd6: succ = 3'd3;
      3'd3: succ = 3'd2;
      3'd2: succ = 3'd1;
      default: succ = 3'd0;
    endcase
  endfunction

  // R1
  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> (q == 3'd0 && !wrap));

  // R2
  assert_step_follows_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    en |=> (q == succ($past(q))));

  // R3
  assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(q));

  // R4
  assert_wrap_set_R4: assert property (@(posedge clk) disable iff (rst)
    (en && q == 3'd1) |=> (wrap && q == 3'd0));

  // R4
  assert_wrap_clear_R4: assert property (@(posedge clk) disable iff (rst)
    !(en && q == 3'd1) |=> !wrap);
endmodule

bind perm_counter perm_counter_chk u_chk (
  .clk  (clk),
  .rst  (rst),
  .en   (en),
  .q    (q),
  .wrap (wrap)
);

// File: tb/perm_counter_test.sv
`timescale 1ns/1ps
module perm_counter_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [2:0] q;
  logic wrap;

  int checks = 0;
  int failures = 0;
  logic [2:0] exp_q = 3'd0;
  logic       exp_wrap = 1'b0;
  logic [2:0] order [8];

  always #2.5 clk = ~clk;

  perm_counter uut (.clk(clk), .rst(rst), .en(en), .q(q), .wrap(wrap));

  function automatic logic [2:0] ref_next(input logic [2:0] c);
    logic [2:0] r = 3'd0;
    for (int i = 0; i < 8; i++)
      if (order[i] == c) r = order[(i + 1) % 8];
    return r;
  endfunction

  task automatic check(input string req, input logic [2:0] aq, input logic aw,
                       input logic [2:0] eq, input logic ew);
    checks++;
    if (aq !== eq || aw !== ew) begin
      failures++;
      $display("FAIL %s: q=%0d wrap=%0b expected q=%0d wrap=%0b", req, aq, aw, eq, ew);
    end
  endtask

  // Drive at falling edge, update the model, sample 1 ns after rising edge.
  task automatic step(input logic r, input logic e, input string req);
    @(negedge clk);
    rst = r;
    en  = e;
    @(posedge clk);
    if (r) begin
      exp_q = 3'd0; exp_wrap = 1'b0;
    end else begin
      exp_wrap = e && (exp_q == 3'd1);
      if (e) exp_q = ref_next(exp_q);
    end
    #1;
    check(req, q, wrap, exp_q, exp_wrap);
  endtask

  initial begin
    order[0] = 3'd0; order[1] = 3'd7; order[2] = 3'd4; order[3] = 3'd5;
    order[4] = 3'd6; order[5] = 3'd3; order[6] = 3'd2; order[7] = 3'd1;

    // R1: reset with enable high
    step(1'b1, 1'b1, "R1");
    step(1'b1, 1'b0, "R1");

    // R2/R4: 20 enabled steps, wrap checked every step
    for (int k = 0; k < 20; k++) step(1'b0, 1'b1, "R2_R4");

    // R3: holds with enable low at a few codes
    for (int k = 0; k < 3; k++) step(1'b0, 1'b0, "R3");
    step(1'b0, 1'b1, "R2");
    for (int k = 0; k < 3; k++) step(1'b0, 1'b0, "R3");

    // R4: stop at code 1, hold, then wrap on the enabled step
    while (exp_q != 3'd1) step(1'b0, 1'b1, "R2");
    step(1'b0, 1'b0, "R4_hold_no_wrap");
    step(1'b0, 1'b1, "R4_wrap");
    step(1'b0, 1'b1, "R4_wrap_drop");

    // R1: mid-sequence reset with enable high, then restart gives 7
    step(1'b0, 1'b1, "R2");
    step(1'b1, 1'b1, "R1_mid");
    step(1'b0, 1'b1, "R1_restart");

    // R5: from each code, 8 steps visit all codes once and return
    for (int s = 0; s < 8; s++) begin
      logic [2:0] start;
      logic [7:0] seen;
      start = q;
      seen = '0;
      for (int k = 0; k < 8; k++) begin
        seen[q] = 1'b1;
        step(1'b0, 1'b1, "R5_step");
      end
      check("R5_return", q, 1'b0, start, 1'b0);
      check("R5_all_codes", {2'b00, &seen}, 1'b0, 3'd1, 1'b0);
      step(1'b0, 1'b1, "R5_advance");
    end

    // R6: enable pulse wholly between edges has no effect
    while (exp_q != 3'd1) step(1'b0, 1'b1, "R2");
    @(negedge clk);
    en = 1'b0;
    #0.5 en = 1'b1;
    #1.0 en = 1'b0;
    @(posedge clk);
    #1;
    check("R6", q, wrap, 3'd1, 1'b0);
    @(posedge clk);
    #1;
    check("R6", q, wrap, 3'd1, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    failures++;
    checks++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule